// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous serial link on which it is the clock master. A register port gives software a control register with separate transmit and receive enables, a status register with three flags (transmit register empty, receive register full, overrun), a transmit data register and a receive data register. Bytes are shifted least significant bit first. The serial clock runs only while a frame is on the wire. Once a byte has moved into the shift engine, the transmit register can take the next byte, so frames can follow one another with no idle time.

Software clears a status flag in two steps: it reads the flag as 1 and then writes 0 to it. Writing 1 to a flag does nothing. Two level outputs, one for transmit empty and one for receive full, work as interrupt or DMA requests. When the DMA qualifier is high during a bus access, a write to the transmit register clears the empty flag and a read of the receive register clears the full flag, so no status access is needed. An overrun stops all frame activity until the overrun flag is cleared. Full-duplex mode can be entered only from the state where both enables are off.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, the control register reads 0x00, status reads 0x01 (only the empty flag set), the serial clock and data outputs are high, and both request outputs are low.
- R2: Register map, selected by the 2-bit address. 0 is control: bit 0 transmit enable, bit 1 receive enable. 1 is status: bit 0 transmit empty, bit 1 receive full, bit 2 overrun. 2 is transmit data, written by software and read back. 3 is receive data. The read data follows the address in the same cycle while select is high and write is low. Otherwise it is 0x00.
- R3: Writing 0 to a status bit clears that flag only if the flag has been read as 1 since it last became 1. Writing 1 to a status bit has no effect.
- R4: A frame starts when the engine is idle, overrun is 0, and either transmit is enabled with the empty flag at 0, or only receive is enabled. A transmit frame loads the transmit register into the shifter and sets the empty flag on the next edge.
- R5: The serial clock idles high. Each half period lasts HALF_PER clock cycles, and a frame opens with one high half period. Eight bits go out least significant bit first. Output data changes on the falling edge of the serial clock, and input data is sampled at the rising edge. A frame lasts 16*HALF_PER cycles.
- R6: When a frame ends with receive enabled and the full flag at 0, the received byte is loaded into the receive register and the full flag is set.
- R7: When a frame ends with receive enabled and the full flag at 1, the overrun flag is set and the receive register keeps its old byte. While overrun is 1, no frame starts. Activity resumes once overrun is cleared.
- R8: The transmit request output equals empty AND transmit enable. The receive request output equals full AND receive enable.
- R9: A write to the transmit register with the DMA qualifier high clears the empty flag. A read of the receive register with the qualifier high clears the full flag.
- R10: While transmit enable is 0, the empty flag is held at 1. Clearing transmit enable aborts any frame in progress: the serial clock and data return high.
- R11: Clearing receive enable leaves the full and overrun flags and the receive register unchanged, and it aborts a receive-only frame.
- R12: A control write that sets both enables is ignored while exactly one enable is set.
- R13: If the next byte is ready before a frame ends, the following frame starts one cycle after the end, so the falling clock edges of bit 7 in the two frames are 16*HALF_PER+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_dma_i | input | 1 | Marks the access as a DMA data transfer |
| bus_rdata_o | output | 8 | Read data |
| sclk_o | output | 1 | Serial clock, master driven |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| txi_o | output | 1 | Transmit-empty request |
| rxi_o | output | 1 | Receive-full request |

## Verification
The shift engine is run in four ways: transmit-only, receive-only, full-duplex from a clean start, and back-to-back transmit with the second byte supplied by a DMA write. Comparing these separates start conditions that depend on mode from errors in bit order and edge timing. A second receive while the full flag is still set tests the overrun lockout. A long window afterwards, with a byte pending, shows whether the clock really stays silent, and clearing the flag shows whether activity resumes. Flag clears tried without a prior read, with 1 written, and with the DMA qualifier show the three clear paths apart. Dropping each enable in the middle of a frame tests the abort path and the preserved flags.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXD  = 2'd2,
        A_RXD  = 2'd3
    } ssx_addr_e;

    localparam int FLAG_TE = 0;
    localparam int FLAG_RF = 1;
    localparam int FLAG_OV = 2;
    localparam int NFLAG   = 3;
endpackage

// File: rtl/ssx_flag.sv
// One status flag: hardware set/clear plus read-then-write-zero software clear.
module ssx_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_zero_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic seen;
    } st_t;

    st_t  q, d;
    logic seen_now, clr;

    always_comb begin
        d        = q;
        seen_now = q.seen | (rd_i & q.flag);
        clr      = hw_clr_i | (wr_zero_i & seen_now);
        d.flag   = hw_set_i ? 1'b1 : (clr ? 1'b0 : q.flag);
        d.seen   = clr ? 1'b0 : (seen_now & d.flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{flag: RST_VAL, seen: 1'b0};
        else        q <= d;
    end

    assign flag_o = q.flag;

    // R3
    unseen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !q.seen && !rd_i && !hw_clr_i) |=> q.flag);
endmodule

// File: rtl/ssx_shift.sv
// Master shift engine: one frame of W bits, LSB first, clock idles high.
module ssx_shift #(
    parameter int W    = 8,
    parameter int HALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         abort_i,
    input  logic [W-1:0] tx_byte_i,
    input  logic         sdi_i,
    output logic         busy_o,
    output logic         sclk_o,
    output logic         sdo_o,
    output logic         done_o,
    output logic [W-1:0] rx_byte_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic          sdo;
        logic          done;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [W-1:0]  txsh;
        logic [W-1:0]  rxsh;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort_i) begin
            d.busy = 1'b0;
            d.sclk = 1'b1;
            d.sdo  = 1'b1;
            d.cnt  = '0;
        end else if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.sclk = 1'b1;
            d.cnt  = '0;
            d.bitn = '0;
            d.txsh = tx_byte_i;
        end else if (q.busy) begin
            if (q.cnt == CW'(HALF - 1)) begin
                d.cnt = '0;
                if (q.sclk) begin
                    d.sclk = 1'b0;
                    d.sdo  = q.txsh[0];
                end else begin
                    d.sclk = 1'b1;
                    d.rxsh = {sdi_i, q.rxsh[W-1:1]};
                    d.txsh = q.txsh >> 1;
                    if (q.bitn == BW'(W - 1)) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.sdo  = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sclk: 1'b1, sdo: 1'b1, done: 1'b0,
                           cnt: '0, bitn: '0, txsh: '0, rxsh: '0};
        else        q <= d;
    end

    assign busy_o    = q.busy;
    assign sclk_o    = q.sclk;
    assign sdo_o     = q.sdo;
    assign done_o    = q.done;
    assign rx_byte_o = q.rxsh;

    // R5
    sclk_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sclk) |-> q.busy);
    // R5
    sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk) && $past(q.busy) && q.busy) |-> $stable(q.sdo));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_PER = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_dma_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              txi_o,
    output logic              rxi_o
);
    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic              frm_tx;
        logic [DATA_W-1:0] tdr;
        logic [DATA_W-1:0] rdr;
    } regs_t;

    regs_t q, d;

    logic              busy, done, start, abort, rx_cap, dup_ok;
    logic              rd_stat, wr_stat, wr_ctrl, wr_txd, rd_rxd;
    logic [DATA_W-1:0] rx_byte, load_byte;
    logic [NFLAG-1:0]  flg, set_v, clr_v;

    always_comb begin
        rd_stat = bus_sel_i & ~bus_wr_i & (bus_addr_i == A_STAT);
        wr_stat = bus_sel_i &  bus_wr_i & (bus_addr_i == A_STAT);
        wr_ctrl = bus_sel_i &  bus_wr_i & (bus_addr_i == A_CTRL);
        wr_txd  = bus_sel_i &  bus_wr_i & (bus_addr_i == A_TXD);
        rd_rxd  = bus_sel_i & ~bus_wr_i & (bus_addr_i == A_RXD);

        start  = ~busy & ~flg[FLAG_OV] &
                 ((q.tx_en & ~flg[FLAG_TE]) | (~q.tx_en & q.rx_en));
        abort  = busy & ((q.frm_tx & ~q.tx_en) | (~q.frm_tx & ~q.rx_en));
        rx_cap = done & q.rx_en;
        load_byte = q.tx_en ? q.tdr : '1;

        set_v[FLAG_TE] = (start & q.tx_en) | ~q.tx_en;
        clr_v[FLAG_TE] = wr_txd & bus_dma_i;
        set_v[FLAG_RF] = rx_cap & ~flg[FLAG_RF];
        clr_v[FLAG_RF] = rd_rxd & bus_dma_i;
        set_v[FLAG_OV] = rx_cap & flg[FLAG_RF];
        clr_v[FLAG_OV] = 1'b0;

        d = q;
        // full duplex only reachable from both-off (or already both-on)
        dup_ok = ~(bus_wdata_i[0] & bus_wdata_i[1]) | (q.tx_en == q.rx_en);
        if (wr_ctrl && dup_ok) begin
            d.tx_en = bus_wdata_i[0];
            d.rx_en = bus_wdata_i[1];
        end
        if (wr_txd) d.tdr = bus_wdata_i;
        if (start) d.frm_tx = q.tx_en;
        if (rx_cap && !flg[FLAG_RF]) d.rdr = rx_byte;

        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            case (bus_addr_i)
                A_CTRL:  bus_rdata_o[1:0] = {q.rx_en, q.tx_en};
                A_STAT:  bus_rdata_o[NFLAG-1:0] = flg;
                A_TXD:   bus_rdata_o = q.tdr;
                default: bus_rdata_o = q.rdr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tx_en: 1'b0, rx_en: 1'b0, frm_tx: 1'b0, tdr: '0, rdr: '0};
        else        q <= d;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        ssx_flag #(.RST_VAL(g == FLAG_TE)) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_set_i  (set_v[g]),
            .hw_clr_i  (clr_v[g]),
            .rd_i      (rd_stat),
            .wr_zero_i (wr_stat & ~bus_wdata_i[g]),
            .flag_o    (flg[g])
        );
    end

    ssx_shift #(.W(DATA_W), .HALF(HALF_PER)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .abort_i   (abort),
        .tx_byte_i (load_byte),
        .sdi_i     (sdi_i),
        .busy_o    (busy),
        .sclk_o    (sclk_o),
        .sdo_o     (sdo_o),
        .done_o    (done),
        .rx_byte_o (rx_byte)
    );

    assign txi_o = flg[FLAG_TE] & q.tx_en;
    assign rxi_o = flg[FLAG_RF] & q.rx_en;

    // R7
    ovr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[FLAG_OV] && !busy) |=> !busy);
    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[FLAG_OV]) |-> $stable(q.rdr));
    // R10
    txoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.tx_en |=> flg[FLAG_TE]);
    // R9
    dma_rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && bus_dma_i && flg[FLAG_RF]) |=> !flg[FLAG_RF]);
endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_sel = 1'b0, b_wr = 1'b0, b_dma = 1'b0;
    logic [1:0] b_addr = 2'd0;
    logic [7:0] b_wd = 8'h00;
    logic       sdi = 1'b1;
    logic [7:0] bus_rdata_o;
    logic       sclk_o, sdo_o, txi_o, rxi_o;

    int errors = 0, checks = 0, cyc = 0;

    sync_serial_xcvr #(.DATA_W(8), .HALF_PER(H)) i_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(b_sel), .bus_wr_i(b_wr),
        .bus_addr_i(b_addr), .bus_wdata_i(b_wd), .bus_dma_i(b_dma),
        .bus_rdata_o(bus_rdata_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .sdi_i(sdi), .txi_o(txi_o), .rxi_o(rxi_o));

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    logic       m_txen = 0, m_rxen = 0, m_te = 1, m_rf = 0, m_ov = 0;
    logic       s_te = 0, s_rf = 0, s_ov = 0;
    logic [7:0] m_tdr = 0, m_rdr = 0, m_byte = 0, m_cap = 0, rxpat = 8'h00;
    logic       m_busy = 0, m_frmtx = 0, m_done = 0;
    int         m_tick = 0;
    logic       rds, wrs, wrc, wrt, rdr_dma, st, ab, fin;
    logic [1:0] r;

    function automatic logic [1:0] fnext(logic f, logic s, logic set, logic hclr,
                                         logic rd, logic wz);
        logic sn, c, nf;
        sn = s | (rd & f);
        c  = hclr | (wz & sn);
        nf = set ? 1'b1 : (c ? 1'b0 : f);
        return {nf, c ? 1'b0 : (sn & nf)};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_txen = 0; m_rxen = 0; m_te = 1; m_rf = 0; m_ov = 0;
            s_te = 0; s_rf = 0; s_ov = 0; m_tdr = 0; m_rdr = 0;
            m_busy = 0; m_done = 0; m_tick = 0; m_frmtx = 0;
        end else begin
            rds = b_sel && !b_wr && b_addr == 2'd1;
            wrs = b_sel &&  b_wr && b_addr == 2'd1;
            wrc = b_sel &&  b_wr && b_addr == 2'd0;
            wrt = b_sel &&  b_wr && b_addr == 2'd2;
            rdr_dma = b_sel && !b_wr && b_addr == 2'd3 && b_dma;
            st  = !m_busy && !m_ov && ((m_txen && !m_te) || (!m_txen && m_rxen));
            ab  = m_busy && ((m_frmtx && !m_txen) || (!m_frmtx && !m_rxen));
            fin = m_busy && !ab && (m_tick == 16 * H - 1);
            if (m_done && m_rxen && !m_rf) m_rdr = m_cap;
            r = fnext(m_ov, s_ov, m_done && m_rxen && m_rf, 1'b0, rds, wrs && !b_wd[2]);
            {m_ov, s_ov} = r;
            r = fnext(m_rf, s_rf, m_done && m_rxen && !m_rf, rdr_dma, rds, wrs && !b_wd[1]);
            {m_rf, s_rf} = r;
            r = fnext(m_te, s_te, (st && m_txen) || !m_txen, wrt && b_dma, rds, wrs && !b_wd[0]);
            {m_te, s_te} = r;
            if (ab) m_busy = 0;
            else if (st) begin
                m_busy = 1; m_tick = 0; m_frmtx = m_txen; m_cap = rxpat;
                m_byte = m_txen ? m_tdr : 8'hFF;
            end else if (m_busy) begin
                if (fin) m_busy = 0; else m_tick++;
            end
            m_done = fin;
            if (wrt) m_tdr = b_wd;
            if (wrc && (!(b_wd[0] && b_wd[1]) || m_txen == m_rxen)) begin
                m_txen = b_wd[0]; m_rxen = b_wd[1];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- per-cycle comparison and serial monitor ----------------
    logic [7:0] mon = 0, e_rd;
    int mcnt = 0, t_last = 0, t_prev = 0, lowcnt = 0, hh;
    logic prev_sclk = 1;

    always @(negedge clk) begin
        hh  = m_tick / H;
        sdi = (m_busy && hh >= 1) ? m_cap[(hh - 1) / 2] : 1'b1;
        #3;
        e_rd = 8'h00;
        if (b_sel && !b_wr) begin
            case (b_addr)
                2'd0: e_rd = {6'b0, m_rxen, m_txen};
                2'd1: e_rd = {5'b0, m_ov, m_rf, m_te};
                2'd2: e_rd = m_tdr;
                default: e_rd = m_rdr;
            endcase
        end
        chk("R5 sclk", sclk_o, !m_busy ? 1 : ((hh % 2) == 0));
        chk("R5 sdo", sdo_o, (m_busy && hh >= 1) ? m_byte[(hh - 1) / 2] : 1'b1);
        chk("R8 txi", txi_o, m_te & m_txen);
        chk("R8 rxi", rxi_o, m_rf & m_rxen);
        chk("R2 rdata", bus_rdata_o, e_rd);
        if (!sclk_o) lowcnt++;
        if (prev_sclk && !sclk_o) begin
            mon = {sdo_o, mon[7:1]};
            mcnt++;
            if (mcnt % 8 == 0) begin t_prev = t_last; t_last = cyc; end
        end
        prev_sclk = sclk_o;
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] v, input logic dma);
        @(negedge clk); b_sel = 1; b_wr = 1; b_addr = a; b_wd = v; b_dma = dma;
        @(negedge clk); b_sel = 0; b_wr = 0; b_dma = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic dma, output logic [7:0] v);
        @(negedge clk); b_sel = 1; b_wr = 0; b_addr = a; b_dma = dma;
        #4 v = bus_rdata_o;
        @(negedge clk); b_sel = 0; b_dma = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        finish_run();
    end

    logic [7:0] v;
    initial begin
        idle(3); rst_n = 1; idle(2);
        // R1 reset state
        rd(2'd1, 0, v); chk("R1 status", v, 8'h01);
        rd(2'd0, 0, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 sclk/sdo", {sclk_o, sdo_o}, 2'b11);
        chk("R1 req", {txi_o, rxi_o}, 2'b00);

        // R3 write 0 without prior read is ignored (tx off: flag also held)
        wr(2'd1, 8'h00, 0); rd(2'd1, 0, v); chk("R3 no-read clear", v, 8'h01);

        // transmit-only frame, R4
        rxpat = 8'h3C;
        wr(2'd0, 8'h01, 0); idle(1); chk("R8 txi after enable", txi_o, 1);
        wr(2'd2, 8'h5A, 0); rd(2'd1, 0, v); mcnt = 0;
        wr(2'd1, 8'h00, 0); idle(3);
        rd(2'd1, 0, v); chk("R4 empty set at start", v, 8'h01);
        idle(40); chk("R5 tx byte lsb first", mon, 8'h5A);
        rd(2'd1, 0, v); chk("R6 tx-only no receive", v, 8'h01);

        // R12 full duplex entry rule
        wr(2'd0, 8'h03, 0); rd(2'd0, 0, v); chk("R12 rejected", v, 8'h01);
        wr(2'd0, 8'h00, 0); wr(2'd0, 8'h03, 0); rd(2'd0, 0, v); chk("R12 accepted", v, 8'h03);

        // full duplex frame, R6
        rxpat = 8'hA5; wr(2'd2, 8'hC3, 0); rd(2'd1, 0, v); mcnt = 0;
        wr(2'd1, 8'h06, 0); idle(40);
        chk("R5 duplex tx byte", mon, 8'hC3);
        chk("R8 rxi when full", rxi_o, 1);
        wr(2'd1, 8'h05, 0); rd(2'd1, 0, v); chk("R3 unread full kept", v, 8'h03);
        wr(2'd1, 8'h07, 0); rd(2'd1, 0, v); chk("R3 write ones no effect", v, 8'h03);
        rd(2'd3, 0, v); chk("R6 received byte", v, 8'hA5);

        // R7 overrun
        rxpat = 8'h44; wr(2'd2, 8'h11, 0); rd(2'd1, 0, v); wr(2'd1, 8'h06, 0); idle(40);
        rd(2'd1, 0, v); chk("R7 overrun set", v, 8'h07);
        rd(2'd3, 0, v); chk("R7 old byte kept", v, 8'hA5);
        rxpat = 8'h0F; wr(2'd2, 8'h22, 0); rd(2'd1, 0, v); wr(2'd1, 8'h06, 0);
        lowcnt = 0; idle(50); chk("R7 frozen clock", lowcnt, 0);
        rd(2'd1, 0, v); chk("R7 byte pending", v, 8'h06);
        rd(2'd3, 1, v); rd(2'd1, 0, v); chk("R9 dma read clears full", v, 8'h04);
        mcnt = 0; wr(2'd1, 8'h03, 0); idle(40);
        rd(2'd3, 0, v); chk("R7 resumed receive", v, 8'h0F);
        chk("R7 resumed transmit", mon, 8'h22);

        // R13 back-to-back with DMA write, transmit-only
        wr(2'd0, 8'h00, 0); wr(2'd0, 8'h01, 0);
        wr(2'd2, 8'h81, 0); rd(2'd1, 0, v); mcnt = 0; wr(2'd1, 8'h06, 0);
        idle(5); wr(2'd2, 8'h7E, 1);
        rd(2'd1, 0, v); chk("R9 dma write clears empty", v[0], 0);
        idle(80);
        chk("R13 second byte", mon, 8'h7E);
        chk("R13 no gap", t_last - t_prev, 16 * H + 1);

        // R10 abort on transmit disable
        wr(2'd2, 8'h99, 0); rd(2'd1, 0, v); wr(2'd1, 8'h06, 0); idle(10);
        wr(2'd0, 8'h00, 0); idle(2);
        chk("R10 abort lines high", {sclk_o, sdo_o}, 2'b11);
        rd(2'd1, 0, v); chk("R10 empty held", v[0], 1);

        // R11 receive-only, then drop receive enable mid-frame
        rd(2'd3, 1, v); rxpat = 8'h6B;
        wr(2'd0, 8'h02, 0); idle(45); wr(2'd0, 8'h00, 0); idle(3);
        rd(2'd1, 0, v); chk("R11 flags kept", v, 8'h03);
        rd(2'd3, 0, v); chk("R11 data kept", v, 8'h6B);
        chk("R11 frame aborted", sclk_o, 1);
        chk("R8 rxi gated by enable", rxi_o, 0);

        idle(5);
        finish_run();
    end
endmodule